// File: doc/BRIEF.md
# Battery-Backed Memory Supply Supervisor

This block watches a digitized supply voltage once per clock and decides how a battery-backed static memory may be used. It has four operating conditions. In the first, the device has never been powered and its battery is still isolated. In the second, the supply is good and the memory is fully usable. In the third, the supply is marginal and the memory is write-protected. In the fourth, the supply has collapsed and the memory is held up by its battery.

The supply code is an unsigned count of millivolts divided by two. The block compares it with three threshold codes: a full-function level, a lower protect level and a much lower battery switchover level. A parameter selects between a tight-tolerance and a wide-tolerance threshold set.

Protection begins when the supply drops below the protect level. It ends only when the supply climbs above the full-function level, so the band between the two levels gives hysteresis. While protection is active, the host's chip-enable, write-enable and output-enable requests are blocked from reaching the memory. The battery is connected to the memory only after the supply has once exceeded the protect level. From then on it stays armed until a factory reset.

Top module: `nvram_supply_guard`

## Requirements
- R1: A synchronous reset clears the armed flag, asserts write-protect and deasserts battery-select.
- R2: The armed flag sets one clock after the first code strictly above the protect threshold. It then stays set through every later supply level until reset.
- R3: Before arming, any code at or below the protect threshold leaves the flag clear, write-protect asserted and battery-select low.
- R4: Write-protect is released only one clock after a code strictly above the full-function threshold.
- R5: From full operation, a code strictly below the protect threshold asserts write-protect one clock later.
- R6: Codes from the protect threshold to the full-function threshold, both included, keep the present protect state unchanged.
- R7: A code strictly below the battery threshold asserts battery-select one clock later, if the flag is armed, and write-protect stays asserted. On a never-armed device, battery-select stays low.
- R8: From battery operation, a code strictly above the battery threshold drops battery-select one clock later and leaves the memory write-protected until R4 applies.
- R9: The memory-side chip, write and output enables equal the host requests while unprotected and are all low while write-protected, with no clock delay.
- R10: With WIDE_TOL=0, the full-function and protect codes are 2375 and 2250. With WIDE_TOL=1, they are 2250 and 2125. The battery code is 1500 in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous factory reset, active high |
| vcode | input | CODE_W | Supply voltage code, mV/2 |
| host_ce | input | 1 | Host chip-enable request, active high |
| host_we | input | 1 | Host write-enable request, active high |
| host_oe | input | 1 | Host output-enable request, active high |
| mem_ce | output | 1 | Gated chip enable to memory |
| mem_we | output | 1 | Gated write enable to memory |
| mem_oe | output | 1 | Gated output enable to memory |
| write_protect | output | 1 | Memory write-protected and isolated |
| batt_sel | output | 1 | Memory powered from battery |
| batt_armed | output | 1 | Battery has been armed |

## Verification
The bench builds two copies of the block from the same reset and host controls. One uses WIDE_TOL=0 and the other WIDE_TOL=1, and each has its own supply code. The tight-tolerance copy is driven to each threshold code and to one count on either side of it. This reaches both edges of the hysteresis band, the battery switchover and the arming edge. The wide-tolerance copy is driven with codes that lie between the two threshold sets, so that the same code releases protection in one variant but not in the other.

// File: rtl/nvram_supply_guard.sv
module nvram_supply_guard #(
  parameter int CODE_W    = 12,
  parameter bit WIDE_TOL  = 1'b0,
  parameter int FULL_TIGHT = 2375,
  parameter int PROT_TIGHT = 2250,
  parameter int FULL_WIDE  = 2250,
  parameter int PROT_WIDE  = 2125,
  parameter int BATT_CODE  = 1500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcode,
  input  logic              host_ce,
  input  logic              host_we,
  input  logic              host_oe,
  output logic              mem_ce,
  output logic              mem_we,
  output logic              mem_oe,
  output logic              write_protect,
  output logic              batt_sel,
  output logic              batt_armed
);

  localparam logic [CODE_W-1:0] FULL_TH = CODE_W'(WIDE_TOL ? FULL_WIDE : FULL_TIGHT);
  localparam logic [CODE_W-1:0] PROT_TH = CODE_W'(WIDE_TOL ? PROT_WIDE : PROT_TIGHT);
  localparam logic [CODE_W-1:0] BATT_TH = CODE_W'(BATT_CODE);

  typedef enum logic [1:0] {ST_DISARMED, ST_NORMAL, ST_PROTECT, ST_BATTERY} sup_state_t;

  sup_state_t state, state_nx;
  logic       armed;

  wire above_full = vcode > FULL_TH;
  wire above_prot = vcode > PROT_TH;
  wire below_prot = vcode < PROT_TH;
  wire below_batt = vcode < BATT_TH;
  wire above_batt = vcode > BATT_TH;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_DISARMED: if (above_full)      state_nx = ST_NORMAL;
                   else if (above_prot) state_nx = ST_PROTECT;
      ST_NORMAL:   if (below_batt)      state_nx = ST_BATTERY;
                   else if (below_prot) state_nx = ST_PROTECT;
      ST_PROTECT:  if (below_batt)      state_nx = ST_BATTERY;
                   else if (above_full) state_nx = ST_NORMAL;
      ST_BATTERY:  if (above_full)      state_nx = ST_NORMAL;
                   else if (above_batt) state_nx = ST_PROTECT;
      default:                          state_nx = ST_DISARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_DISARMED;
      armed <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_DISARMED && above_prot) armed <= 1'b1;
    end
  end

  assign write_protect = (state != ST_NORMAL);
  assign batt_sel      = (state == ST_BATTERY) && armed;
  assign batt_armed    = armed;

  assign mem_ce = host_ce && !write_protect;
  assign mem_we = host_we && !write_protect;
  assign mem_oe = host_oe && !write_protect;

endmodule

module nvram_supply_guard_chk #(
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] FULL_TH = 2375,
  parameter logic [CODE_W-1:0] PROT_TH = 2250,
  parameter logic [CODE_W-1:0] BATT_TH = 1500
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] vcode,
  input logic              mem_ce,
  input logic              mem_we,
  input logic              mem_oe,
  input logic              write_protect,
  input logic              batt_sel,
  input logic              batt_armed
);

  assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    batt_armed |=> batt_armed);

  assert_stay_disarmed_R3: assert property (@(posedge clk) disable iff (rst)
    (!batt_armed && vcode <= PROT_TH) |=> (!batt_armed && write_protect && !batt_sel));

  assert_release_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
    (!write_protect && $past(write_protect)) |-> ($past(vcode) > FULL_TH));

  assert_protect_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!write_protect && vcode < PROT_TH) |=> write_protect);

  assert_battery_needs_arm_R7: assert property (@(posedge clk) disable iff (rst)
    batt_sel |-> (batt_armed && write_protect));

  assert_battery_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (batt_armed && vcode < BATT_TH) |=> batt_sel);

  assert_gate_closed_R9: assert property (@(posedge clk) disable iff (rst)
    write_protect |-> (!mem_ce && !mem_we && !mem_oe));

endmodule

bind nvram_supply_guard nvram_supply_guard_chk #(
  .CODE_W(CODE_W), .FULL_TH(FULL_TH), .PROT_TH(PROT_TH), .BATT_TH(BATT_TH)
) i_chk (
  .clk(clk), .rst(rst), .vcode(vcode),
  .mem_ce(mem_ce), .mem_we(mem_we), .mem_oe(mem_oe),
  .write_protect(write_protect), .batt_sel(batt_sel), .batt_armed(batt_armed)
);

// File: tb/test_nvram_supply_guard.sv
`timescale 1ns/1ps
module test_nvram_supply_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] vcode = 12'd0;
  logic [11:0] vcode_w = 12'd0;
  logic        host_ce = 1'b0, host_we = 1'b0, host_oe = 1'b0;
  logic        mem_ce, mem_we, mem_oe, wp, bsel, armed;
  logic        mem_ce_w, mem_we_w, mem_oe_w, wp_w, bsel_w, armed_w;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  nvram_supply_guard #(.WIDE_TOL(1'b0)) i_nvram_supply_guard (
    .clk(clk), .rst(rst), .vcode(vcode),
    .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_oe(mem_oe),
    .write_protect(wp), .batt_sel(bsel), .batt_armed(armed));

  nvram_supply_guard #(.WIDE_TOL(1'b1)) i_nvram_supply_guard_wide (
    .clk(clk), .rst(rst), .vcode(vcode_w),
    .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .mem_ce(mem_ce_w), .mem_we(mem_we_w), .mem_oe(mem_oe_w),
    .write_protect(wp_w), .batt_sel(bsel_w), .batt_armed(armed_w));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int code);
    vcode = 12'(code);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "armed", armed, 0);
    check("R1", "write_protect", wp, 1);
    check("R1", "batt_sel", bsel, 0);
  endtask

  task automatic t_disarmed();
    step(2250);
    check("R3", "armed at protect code", armed, 0);
    check("R3", "wp at protect code", wp, 1);
    step(1000);
    check("R3", "batt_sel unarmed low code", bsel, 0);
    check("R7", "unarmed no battery", bsel, 0);
    check("R3", "armed after low code", armed, 0);
  endtask

  task automatic t_arm_and_release();
    step(2251);
    check("R2", "armed after 2251", armed, 1);
    check("R4", "still protected at 2251", wp, 1);
    step(2375);
    check("R6", "protected at full code", wp, 1);
    step(2376);
    check("R4", "released at 2376", wp, 0);
    host_ce = 1'b1; host_we = 1'b1; host_oe = 1'b1;
    #0.1;
    check("R9", "ce passes", mem_ce, 1);
    check("R9", "we passes", mem_we, 1);
    check("R9", "oe passes", mem_oe, 1);
    host_we = 1'b0;
    #0.1;
    check("R9", "we follows host", mem_we, 0);
    host_we = 1'b1;
  endtask

  task automatic t_hysteresis();
    step(2250);
    check("R6", "normal kept at protect code", wp, 0);
    step(2249);
    check("R5", "protect below 2250", wp, 1);
    check("R9", "ce blocked", mem_ce, 0);
    check("R9", "we blocked", mem_we, 0);
    check("R9", "oe blocked", mem_oe, 0);
    step(2375);
    check("R6", "protect kept at full code", wp, 1);
    step(2300);
    check("R6", "protect kept mid band", wp, 1);
  endtask

  task automatic t_battery();
    step(1499);
    check("R7", "battery below 1500", bsel, 1);
    check("R7", "wp on battery", wp, 1);
    step(1500);
    check("R8", "battery held at 1500", bsel, 1);
    step(1501);
    check("R8", "battery dropped at 1501", bsel, 0);
    check("R8", "still protected after switchback", wp, 1);
    step(2375);
    check("R8", "no release at full code", wp, 1);
    step(2400);
    check("R4", "released after battery episode", wp, 0);
    step(900);
    check("R7", "direct fall to battery", bsel, 1);
    check("R2", "armed kept on battery", armed, 1);
    step(0);
    check("R2", "armed kept at zero", armed, 1);
  endtask

  task automatic t_rearm_reset();
    do_reset();
    check("R1", "armed cleared again", armed, 0);
    check("R1", "batt_sel after reset", bsel, 0);
    step(1000);
    check("R7", "unarmed after reset no battery", bsel, 0);
  endtask

  task automatic t_wide();
    vcode_w = 12'd2200;
    vcode   = 12'd2200;
    @(posedge clk); @(negedge clk);
    check("R10", "wide armed at 2200", armed_w, 1);
    check("R10", "tight not armed at 2200", armed, 0);
    vcode_w = 12'd2251;
    vcode   = 12'd2251;
    @(posedge clk); @(negedge clk);
    check("R10", "wide released at 2251", wp_w, 0);
    check("R10", "tight protected at 2251", wp, 1);
    vcode_w = 12'd2125;
    @(posedge clk); @(negedge clk);
    check("R10", "wide holds at 2125", wp_w, 0);
    vcode_w = 12'd2124;
    @(posedge clk); @(negedge clk);
    check("R10", "wide protects at 2124", wp_w, 1);
    vcode_w = 12'd1499;
    @(posedge clk); @(negedge clk);
    check("R10", "wide battery at 1499", bsel_w, 1);
  endtask

  initial begin
    t_reset();
    t_disarmed();
    t_arm_and_release();
    t_hysteresis();
    t_battery();
    t_rearm_reset();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule